// File: doc/BRIEF.md
# Eager Transactional Conflict Detector

This per-core block supports hardware transactions that use eager versioning and eager conflict detection. Stores made inside a transaction update the local line store in place, so they are visible at once. Before the first transactional store to a line overwrites it, the old value is saved in an undo log, and the save is also reported on a log-write port. The block keeps one read bit and one write bit for each line. Coherence requests from other transactions are checked against these bits. A conflicting request gets a NACK so that the requester stalls and retries later. Any other request gets an ACK.

A commit takes one cycle: the sets are cleared, the log pointer goes back to zero and the new data stays in place. An abort comes from an external contention-manager input, which can break deadlocks. It replays the log newest-first, writing one old value back per cycle and reporting each write on a restore port. When the log is empty the sets are cleared.

The controller has three states. IDLE means no transaction is open. ACTIVE means a transaction is running. UNDO means the log is being drained after an abort. The transitions are:
- BEGIN: IDLE to ACTIVE on `tx_begin`.
- COMMIT: ACTIVE to IDLE on `tx_commit` when no abort is present.
- ABORT: ACTIVE to UNDO on `cm_abort`.
- STEP: UNDO to UNDO while the log holds entries.
- RESTORED: UNDO to IDLE once the log is empty.

Top module: `tm_eager_detect`

## Requirements
- R1: After reset the block is in IDLE (`in_tx`=0, `undoing`=0), no response, log-write or restore pulse is present, and every line reads 0.
- R2: A store in ACTIVE to a line whose write bit is clear updates the line at the clock edge. In the next cycle it gives one `log_wr_valid` pulse that carries the line, its value before the store, and `log_wr_idx` equal to the number of entries already logged in this transaction (the first entry is index 0).
- R3: A store in ACTIVE to a line whose write bit is already set updates the line and makes no log write.
- R4: Each `snp_valid` gets exactly one `snp_resp_valid` in the following cycle. `snp_nack`=1 (NACK) when the line is in the write set, or when the request is a write (`snp_is_write`=1) and the line is in the read set. Otherwise `snp_nack`=0 (ACK).
- R5: A remote read of a line that is only in the read set gets an ACK, and a remote read or write of an untouched line gets an ACK.
- R6: In IDLE every snoop is answered with an ACK.
- R7: A commit returns to IDLE in the next cycle, keeps the stored data, clears both sets and resets the log index to 0.
- R8: An abort enters UNDO. Each following cycle restores one entry newest-first, with `rest_valid`, `rest_line` and `rest_data` showing the entry being written back. After the last entry there is one cycle with no restore, then the block returns to IDLE with both sets cleared.
- R9: When `cm_abort` and `tx_commit` arrive together in ACTIVE, the abort wins.
- R10: A store in IDLE updates the line and makes no log write. A store during UNDO is ignored and the line is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tx_begin | input | 1 | Open a transaction |
| tx_commit | input | 1 | Commit the running transaction |
| cm_abort | input | 1 | Abort forced by the contention manager |
| ld_valid | input | 1 | Local load; adds the line to the read set in ACTIVE |
| ld_line | input | LINE_W | Load line index |
| ld_data | output | DATA_W | Current value of line `ld_line` |
| st_valid | input | 1 | Local store |
| st_line | input | LINE_W | Store line index |
| st_data | input | DATA_W | Store data |
| snp_valid | input | 1 | Remote coherence request |
| snp_line | input | LINE_W | Line of the remote request |
| snp_is_write | input | 1 | 1 = remote write, 0 = remote read |
| snp_resp_valid | output | 1 | Response strobe, one cycle after the request |
| snp_nack | output | 1 | 1 = NACK (stall and retry), 0 = ACK |
| log_wr_valid | output | 1 | Undo-log write pulse |
| log_wr_idx | output | LINE_W | Log slot written |
| log_wr_line | output | LINE_W | Line being saved |
| log_wr_old | output | DATA_W | Old value being saved |
| rest_valid | output | 1 | Restore write in progress |
| rest_line | output | LINE_W | Line being restored |
| rest_data | output | DATA_W | Value written back |
| in_tx | output | 1 | Controller is in ACTIVE |
| undoing | output | 1 | Controller is in UNDO |

## Verification
The assertions assume that at most one snoop arrives per cycle and that line indices are in range. They also rely on the log never holding more entries than there are lines, which follows from logging a line only while its write bit is clear. The stimulus raises `tx_begin` only in IDLE and raises commit or abort only in ACTIVE, except in the case where both arrive together on purpose. The stimulus drives a store during UNDO only to show that it is ignored, and it always lets a drain finish before opening the next transaction.

// File: rtl/tmcd_pkg.sv
package tmcd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_UNDO   = 2'd2
    } tx_state_e;
endpackage

// File: rtl/tmcd_ctrl.sv
module tmcd_ctrl
    import tmcd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tx_begin,
    input  logic      tx_commit,
    input  logic      cm_abort,
    input  logic      log_empty,
    output tx_state_e state,
    output logic      clear_sets,
    output logic      log_reset,
    output logic      undo_step
);
    tx_state_e state_d;

    // next-state logic: BEGIN, COMMIT, ABORT, STEP, RESTORED
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:   if (tx_begin) state_d = ST_ACTIVE;
            ST_ACTIVE: begin
                if (cm_abort)       state_d = ST_UNDO;
                else if (tx_commit) state_d = ST_IDLE;
            end
            ST_UNDO:   if (log_empty) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        clear_sets = 1'b0;
        log_reset  = 1'b0;
        undo_step  = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_ACTIVE: begin
                if (!cm_abort && tx_commit) begin
                    clear_sets = 1'b1;
                    log_reset  = 1'b1;
                end
            end
            ST_UNDO: begin
                if (log_empty) clear_sets = 1'b1;
                else           undo_step  = 1'b1;
            end
            default: ;
        endcase
    end

    p_abort_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && cm_abort) |=> (state == ST_UNDO));
endmodule

// File: rtl/tmcd_sets.sv
module tmcd_sets #(
    parameter int LINES  = 8,
    parameter int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              track,
    input  logic              check_en,
    input  logic              clear,
    input  logic              rd_mark,
    input  logic [LINE_W-1:0] rd_line,
    input  logic              wr_mark,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              snp_valid,
    input  logic [LINE_W-1:0] snp_line,
    input  logic              snp_is_write,
    output logic              wr_hit,
    output logic              snp_resp_valid,
    output logic              snp_nack
);
    logic [LINES-1:0] rd_q;
    logic [LINES-1:0] wr_q;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rd_q[g] <= 1'b0;
                wr_q[g] <= 1'b0;
            end else if (clear) begin
                rd_q[g] <= 1'b0;
                wr_q[g] <= 1'b0;
            end else if (track) begin
                if (rd_mark && rd_line == LINE_W'(g)) rd_q[g] <= 1'b1;
                if (wr_mark && wr_line == LINE_W'(g)) wr_q[g] <= 1'b1;
            end
        end
    end

    assign wr_hit = wr_q[wr_line];

    logic conflict;
    assign conflict = check_en &&
                      (wr_q[snp_line] || (snp_is_write && rd_q[snp_line]));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snp_resp_valid <= 1'b0;
            snp_nack       <= 1'b0;
        end else begin
            snp_resp_valid <= snp_valid;
            snp_nack       <= snp_valid && conflict;
        end
    end

    p_clear_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (rd_q == '0 && wr_q == '0));
    p_nack_has_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        snp_nack |-> snp_resp_valid);
endmodule

// File: rtl/tmcd_undo_log.sv
module tmcd_undo_log #(
    parameter int LINES  = 8,
    parameter int DATA_W = 16,
    parameter int LINE_W = $clog2(LINES),
    parameter int PTR_W  = $clog2(LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [LINE_W-1:0] push_line,
    input  logic [DATA_W-1:0] push_old,
    input  logic              pop,
    input  logic              reset_ptr,
    output logic              empty,
    output logic [LINE_W-1:0] top_line,
    output logic [DATA_W-1:0] top_data,
    output logic              log_wr_valid,
    output logic [LINE_W-1:0] log_wr_idx,
    output logic [LINE_W-1:0] log_wr_line,
    output logic [DATA_W-1:0] log_wr_old
);
    logic [LINE_W-1:0] line_q [LINES];
    logic [DATA_W-1:0] data_q [LINES];
    logic [PTR_W-1:0]  ptr;
    logic [PTR_W-1:0]  top_idx;

    assign empty    = (ptr == '0);
    assign top_idx  = ptr - PTR_W'(1);
    assign top_line = line_q[top_idx[LINE_W-1:0]];
    assign top_data = data_q[top_idx[LINE_W-1:0]];

    always_ff @(posedge clk) begin
        if (push) begin
            line_q[ptr[LINE_W-1:0]] <= push_line;
            data_q[ptr[LINE_W-1:0]] <= push_old;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr          <= '0;
            log_wr_valid <= 1'b0;
            log_wr_idx   <= '0;
            log_wr_line  <= '0;
            log_wr_old   <= '0;
        end else begin
            log_wr_valid <= push;
            if (push) begin
                log_wr_idx  <= ptr[LINE_W-1:0];
                log_wr_line <= push_line;
                log_wr_old  <= push_old;
            end
            if (reset_ptr)  ptr <= '0;
            else if (push)  ptr <= ptr + PTR_W'(1);
            else if (pop)   ptr <= ptr - PTR_W'(1);
        end
    end

    p_log_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PTR_W'(LINES));
    p_log_write_counted_r2: assert property (@(posedge clk) disable iff (!rst_n)
        log_wr_valid |-> !empty || $past(reset_ptr));
    p_pop_descends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !reset_ptr) |=> (ptr + PTR_W'(1)) == $past(ptr));
endmodule

// File: rtl/tm_eager_detect.sv
module tm_eager_detect
    import tmcd_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int DATA_W = 16,
    parameter int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_begin,
    input  logic              tx_commit,
    input  logic              cm_abort,
    input  logic              ld_valid,
    input  logic [LINE_W-1:0] ld_line,
    output logic [DATA_W-1:0] ld_data,
    input  logic              st_valid,
    input  logic [LINE_W-1:0] st_line,
    input  logic [DATA_W-1:0] st_data,
    input  logic              snp_valid,
    input  logic [LINE_W-1:0] snp_line,
    input  logic              snp_is_write,
    output logic              snp_resp_valid,
    output logic              snp_nack,
    output logic              log_wr_valid,
    output logic [LINE_W-1:0] log_wr_idx,
    output logic [LINE_W-1:0] log_wr_line,
    output logic [DATA_W-1:0] log_wr_old,
    output logic              rest_valid,
    output logic [LINE_W-1:0] rest_line,
    output logic [DATA_W-1:0] rest_data,
    output logic              in_tx,
    output logic              undoing
);
    localparam int PTR_W = $clog2(LINES + 1);

    tx_state_e   state;
    logic        clear_sets, log_reset, undo_step, log_empty, wr_hit, log_push;
    logic [LINE_W-1:0] top_line;
    logic [DATA_W-1:0] top_data;
    logic [DATA_W-1:0] mem [LINES];

    assign in_tx    = (state == ST_ACTIVE);
    assign undoing  = (state == ST_UNDO);
    assign log_push = st_valid && in_tx && !wr_hit;

    tmcd_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_commit(tx_commit),
        .cm_abort(cm_abort), .log_empty(log_empty), .state(state),
        .clear_sets(clear_sets), .log_reset(log_reset), .undo_step(undo_step)
    );

    tmcd_sets #(.LINES(LINES), .LINE_W(LINE_W)) u_sets (
        .clk(clk), .rst_n(rst_n), .track(in_tx), .check_en(state != ST_IDLE),
        .clear(clear_sets), .rd_mark(ld_valid), .rd_line(ld_line),
        .wr_mark(st_valid), .wr_line(st_line), .snp_valid(snp_valid),
        .snp_line(snp_line), .snp_is_write(snp_is_write), .wr_hit(wr_hit),
        .snp_resp_valid(snp_resp_valid), .snp_nack(snp_nack)
    );

    tmcd_undo_log #(.LINES(LINES), .DATA_W(DATA_W), .LINE_W(LINE_W),
                    .PTR_W(PTR_W)) u_log (
        .clk(clk), .rst_n(rst_n), .push(log_push), .push_line(st_line),
        .push_old(mem[st_line]), .pop(undo_step), .reset_ptr(log_reset),
        .empty(log_empty), .top_line(top_line), .top_data(top_data),
        .log_wr_valid(log_wr_valid), .log_wr_idx(log_wr_idx),
        .log_wr_line(log_wr_line), .log_wr_old(log_wr_old)
    );

    assign rest_valid = undo_step;
    assign rest_line  = top_line;
    assign rest_data  = top_data;
    assign ld_data    = mem[ld_line];

    // in-place line store: restore first, stores blocked while undoing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) mem[i] <= '0;
        end else if (undo_step) begin
            mem[top_line] <= top_data;
        end else if (st_valid && !undoing) begin
            mem[st_line] <= st_data;
        end
    end

    p_resp_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> snp_resp_valid);
    p_idle_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && state == ST_IDLE) |=> !snp_nack);
    p_restore_in_undo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rest_valid |-> undoing && !log_wr_valid);
    p_no_log_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && state == ST_IDLE) |=> !log_wr_valid);
endmodule

// File: tb/tm_eager_detect_bench.sv
`timescale 1ns/1ps
module tm_eager_detect_bench;
    localparam int LINES = 8, DATA_W = 16, LINE_W = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tx_begin = 0, tx_commit = 0, cm_abort = 0;
    logic ld_valid = 0, st_valid = 0, snp_valid = 0, snp_is_write = 0;
    logic [LINE_W-1:0] ld_line = '0, st_line = '0, snp_line = '0;
    logic [DATA_W-1:0] st_data = '0;
    logic [DATA_W-1:0] ld_data, log_wr_old, rest_data;
    logic [LINE_W-1:0] log_wr_idx, log_wr_line, rest_line;
    logic snp_resp_valid, snp_nack, log_wr_valid, rest_valid, in_tx, undoing;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tm_eager_detect #(.LINES(LINES), .DATA_W(DATA_W)) u_tm_eager_detect (.*);

    // snoop vectors: {line[2:0], is_write, expected_nack}
    localparam logic [4:0] SNP_VEC [8] = '{
        {3'd1, 1'b0, 1'b0}, {3'd1, 1'b1, 1'b1}, {3'd2, 1'b0, 1'b1},
        {3'd2, 1'b1, 1'b1}, {3'd3, 1'b0, 1'b1}, {3'd4, 1'b0, 1'b0},
        {3'd4, 1'b1, 1'b0}, {3'd5, 1'b0, 1'b1}
    };

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic peek(input int line, input int exp, input string req);
        ld_line = LINE_W'(line); #0.5;
        check(ld_data == DATA_W'(exp), req, ld_data, exp);
    endtask

    task automatic store(input int line, input int val);
        st_valid = 1; st_line = LINE_W'(line); st_data = DATA_W'(val);
        tick();
        st_valid = 0;
    endtask

    task automatic snoop(input int line, input bit wr, input bit exp, input string req);
        snp_valid = 1; snp_line = LINE_W'(line); snp_is_write = wr;
        tick();
        snp_valid = 0;
        check(snp_resp_valid && snp_nack == exp, req, {snp_resp_valid, snp_nack}, {1'b1, exp});
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick(); rst_n = 1; tick();
        // R1 reset state
        check(!in_tx && !undoing, "R1", {in_tx, undoing}, 0);
        check(!snp_resp_valid && !log_wr_valid && !rest_valid, "R1",
              {snp_resp_valid, log_wr_valid, rest_valid}, 0);
        peek(3, 0, "R1");
        // R6 snoop in IDLE
        snoop(2, 1, 0, "R6");
        // R10 non-transactional store
        store(5, 16'h1111);
        check(!log_wr_valid, "R10", log_wr_valid, 0);
        peek(5, 16'h1111, "R10");

        tx_begin = 1; tick(); tx_begin = 0;
        check(in_tx, "R8 begin", in_tx, 1);
        ld_valid = 1; ld_line = 1; tick(); ld_valid = 0;
        store(2, 16'hAAAA);
        check(log_wr_valid && log_wr_idx == 0 && log_wr_line == 2 && log_wr_old == 0,
              "R2", {log_wr_valid, log_wr_idx, log_wr_line, log_wr_old}, {1'b1, 3'd0, 3'd2, 16'h0});
        peek(2, 16'hAAAA, "R2");
        ld_valid = 1; ld_line = 3; store(3, 16'hBBBB); ld_valid = 0;
        check(log_wr_valid && log_wr_idx == 1 && log_wr_line == 3, "R2",
              {log_wr_idx, log_wr_line}, {3'd1, 3'd3});
        store(2, 16'hCCCC);
        check(!log_wr_valid, "R3", log_wr_valid, 0);
        peek(2, 16'hCCCC, "R3");
        store(5, 16'h5555);
        check(log_wr_valid && log_wr_idx == 2 && log_wr_old == 16'h1111, "R2",
              {log_wr_idx, log_wr_old}, {3'd2, 16'h1111});

        // vector walk, R4 and R5
        for (int i = 0; i < 8; i++) begin
            snoop(SNP_VEC[i][4:2], SNP_VEC[i][1], SNP_VEC[i][0],
                  SNP_VEC[i][0] ? "R4" : "R5");
        end

        // R8 abort and reverse replay; R10 store during UNDO ignored
        cm_abort = 1; tick(); cm_abort = 0;
        check(undoing, "R8", undoing, 1);
        check(rest_valid && rest_line == 5 && rest_data == 16'h1111, "R8",
              {rest_line, rest_data}, {3'd5, 16'h1111});
        st_valid = 1; st_line = 7; st_data = 16'h7777;
        tick(); st_valid = 0;
        check(rest_valid && rest_line == 3 && rest_data == 0, "R8",
              {rest_line, rest_data}, {3'd3, 16'h0});
        tick();
        check(rest_valid && rest_line == 2 && rest_data == 0, "R8",
              {rest_line, rest_data}, {3'd2, 16'h0});
        tick();
        check(!rest_valid && undoing, "R8", {rest_valid, undoing}, 1);
        tick();
        check(!undoing && !in_tx, "R8", {undoing, in_tx}, 0);
        peek(5, 16'h1111, "R8"); peek(2, 0, "R8"); peek(3, 0, "R8");
        peek(7, 0, "R10");
        snoop(1, 1, 0, "R8 sets cleared");

        // R7 commit
        tx_begin = 1; tick(); tx_begin = 0;
        store(4, 16'h4444);
        check(log_wr_valid && log_wr_idx == 0, "R8 log empty after drain", log_wr_idx, 0);
        tx_commit = 1; tick(); tx_commit = 0;
        check(!in_tx && !undoing, "R7", {in_tx, undoing}, 0);
        peek(4, 16'h4444, "R7");
        snoop(4, 1, 0, "R7");
        tx_begin = 1; tick(); tx_begin = 0;
        store(4, 16'h4445);
        check(log_wr_valid && log_wr_idx == 0 && log_wr_old == 16'h4444, "R7",
              {log_wr_idx, log_wr_old}, {3'd0, 16'h4444});

        // R9 abort beats commit
        cm_abort = 1; tx_commit = 1; tick(); cm_abort = 0; tx_commit = 0;
        check(undoing, "R9", undoing, 1);
        check(rest_valid && rest_line == 4 && rest_data == 16'h4444, "R9",
              {rest_line, rest_data}, {3'd4, 16'h4444});
        tick(); tick();
        check(!undoing && !in_tx, "R9", {undoing, in_tx}, 0);
        peek(4, 16'h4444, "R9");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule